// File: doc/BRIEF.md
# Operand Cache Array Access Window

This block gives software direct load and store access to the tag/status array and the data array of a two-way operand cache. A request carries a 32-bit address, a write flag and 32-bit write data. The top address byte picks the array. Lower address bits pick the way, the entry (line index) and, for the data array, the 32-bit word inside the line. Plain writes replace the stored contents. An associative tag write updates the valid and dirty bits only when the stored tag of the addressed line equals the supplied tag. When that comparison fails, the write is discarded and nothing reports it.

A RAM-mode input moves the way select from address bit 14 to address bit 13. Both arrays are built from registers inside the block.

The controller is a three-state machine:
- `ST_IDLE` accepts requests and performs plain writes in the cycle they are accepted.
- `ST_READ_RESP` returns read data for exactly one cycle.
- `ST_ASSOC_CHECK` compares tags and conditionally updates the line.

Transitions:
- Idle to read-response on an accepted read.
- Idle to assoc-check on an accepted associative tag write.
- Idle to idle on any other accepted write, or when no request is present.
- Read-response back to idle, always.
- Assoc-check back to idle, always.

Top module: `opcache_window`

## Requirements
- R1: Address byte [31:24] = 0xF4 selects the tag/status array and 0xF5 selects the data array. An access to one array never changes the other.
- R2: In normal mode (ram_mode = 0), address bit 14 selects the way and address bits [ENTRY_LSB +: ENTRY_BITS] select the entry, with ENTRY_LSB = 5. This applies to both arrays.
- R3: For data-array accesses, address bits [4:2] select one of the eight 32-bit words of the line. Address bits [1:0] are ignored.
- R4: With ram_mode = 1, address bit 13 selects the way and bit 14 is ignored.
- R5: The tag/status word holds the tag in bits [31:10], the dirty bit in bit 1 and the valid bit in bit 0. A tag-array read returns 0 in bits [9:2].
- R6: A tag-array write with address bit 3 clear replaces the tag, dirty and valid bits of the addressed line.
- R7: A tag-array write with address bit 3 set (associative) whose write-data bits [31:10] equal the stored tag updates only the valid and dirty bits. The stored tag is kept.
- R8: An associative tag write whose tag mismatches changes no state and raises no indication.
- R9: A write outside the 0xF4 and 0xF5 regions changes nothing, and a read there returns 0.
- R10: A read accepted on a clock edge gives rsp_valid high for exactly the following cycle, with rsp_rdata valid in that cycle. req_ready is low during the response cycle and during the associative check cycle.
- R11: Reset clears every valid and dirty bit in both ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_mode | input | 1 | Selects address bit 13 instead of bit 14 as the way select |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when req_valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench runs associative writes that hit and that miss on lines it has already written. A design that ignored the compare would overwrite the status of the wrong line. A design that rewrote the tag on a hit would corrupt later reads.

It sets address bit 14 and bit 13 to opposite values in each mode. A way select wired to the wrong bit shows up as data appearing in the other way.

It writes reserved tag-word bits as ones, so reads that echo them are caught. It also writes to unmapped regions that alias a written line, which exposes any design that decodes fewer address bits than it should.

A second reset after lines were marked valid and dirty must leave them clear.

// File: rtl/ocw_pkg.sv
package ocw_pkg;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_TAG,
        RGN_DATA
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ_RESP,
        ST_ASSOC_CHECK
    } state_e;

    localparam logic [7:0] SEL_TAG_ARRAY  = 8'hF4;
    localparam logic [7:0] SEL_DATA_ARRAY = 8'hF5;
    localparam int         TAG_LSB        = 10;
    localparam int         TAG_W          = 32 - TAG_LSB;
    localparam int         WORD_LSB       = 2;
    localparam int         ASSOC_BIT      = 3;
    localparam int         DIRTY_BIT      = 1;
    localparam int         VALID_BIT      = 0;

endpackage

// File: rtl/ocw_decode.sv
module ocw_decode
    import ocw_pkg::*;
#(
    parameter int ENTRY_BITS  = 4,
    parameter int ENTRY_LSB   = 5,
    parameter int WORD_BITS   = 3,
    parameter int WAY_BIT     = 14,
    parameter int RAM_WAY_BIT = 13
) (
    input  logic [31:0]           addr,
    input  logic                  ram_mode,
    output region_e               region,
    output logic                  way,
    output logic [ENTRY_BITS-1:0] idx,
    output logic [WORD_BITS-1:0]  word,
    output logic                  assoc
);

    logic unused_addr_bits;
    assign unused_addr_bits = ^addr;

    always_comb begin
        unique case (addr[31:24])
            SEL_TAG_ARRAY:  region = RGN_TAG;
            SEL_DATA_ARRAY: region = RGN_DATA;
            default:        region = RGN_NONE;
        endcase
    end

    assign way   = ram_mode ? addr[RAM_WAY_BIT] : addr[WAY_BIT];
    assign idx   = addr[ENTRY_LSB +: ENTRY_BITS];
    assign word  = addr[WORD_LSB +: WORD_BITS];
    assign assoc = addr[ASSOC_BIT];

endmodule

// File: rtl/ocw_tag_store.sv
module ocw_tag_store
    import ocw_pkg::*;
#(
    parameter int ENTRY_BITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_way,
    input  logic [ENTRY_BITS-1:0] wr_idx,
    input  logic                  wr_tag_en,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic                  wr_valid,
    input  logic                  wr_dirty,
    input  logic                  rd_way,
    input  logic [ENTRY_BITS-1:0] rd_idx,
    output logic [TAG_W-1:0]      rd_tag,
    output logic                  rd_valid,
    output logic                  rd_dirty
);

    localparam int ENTRIES = 1 << ENTRY_BITS;
    localparam int WAYS    = 2;

    logic [TAG_W-1:0] way_tag [WAYS];
    logic             way_v   [WAYS];
    logic             way_d   [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0]   tag_q [ENTRIES];
        logic [ENTRIES-1:0] valid_q;
        logic [ENTRIES-1:0] dirty_q;
        logic               sel;

        assign sel = wr_en && (wr_way == 1'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= '0;
                dirty_q <= '0;
            end else if (sel) begin
                valid_q[wr_idx] <= wr_valid;
                dirty_q[wr_idx] <= wr_dirty;
            end
        end

        always_ff @(posedge clk) begin
            if (sel && wr_tag_en) begin
                tag_q[wr_idx] <= wr_tag;
            end
        end

        assign way_tag[w] = tag_q[rd_idx];
        assign way_v[w]   = valid_q[rd_idx];
        assign way_d[w]   = dirty_q[rd_idx];
    end

    assign rd_tag   = way_tag[rd_way];
    assign rd_valid = way_v[rd_way];
    assign rd_dirty = way_d[rd_way];

endmodule

// File: rtl/ocw_data_store.sv
module ocw_data_store #(
    parameter int ENTRY_BITS = 4,
    parameter int WORD_BITS  = 3
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic                  wr_way,
    input  logic [ENTRY_BITS-1:0] wr_idx,
    input  logic [WORD_BITS-1:0]  wr_word,
    input  logic [31:0]           wr_data,
    input  logic                  rd_way,
    input  logic [ENTRY_BITS-1:0] rd_idx,
    input  logic [WORD_BITS-1:0]  rd_word,
    output logic [31:0]           rd_data
);

    localparam int AW    = ENTRY_BITS + WORD_BITS;
    localparam int DEPTH = 1 << AW;
    localparam int WAYS  = 2;

    logic [31:0] way_data [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [31:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == 1'(w))) begin
                mem_q[{wr_idx, wr_word}] <= wr_data;
            end
        end

        assign way_data[w] = mem_q[{rd_idx, rd_word}];
    end

    assign rd_data = way_data[rd_way];

endmodule

// File: rtl/opcache_window.sv
module opcache_window
    import ocw_pkg::*;
#(
    parameter int ENTRY_BITS  = 4,
    parameter int ENTRY_LSB   = 5,
    parameter int WAY_BIT     = 14,
    parameter int RAM_WAY_BIT = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ram_mode,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata
);

    localparam int WORD_BITS = 3;
    localparam int RSV_W     = TAG_LSB - 2;

    state_e state_q, state_d;

    region_e               dec_region;
    logic                  dec_way;
    logic [ENTRY_BITS-1:0] dec_idx;
    logic [WORD_BITS-1:0]  dec_word;
    logic                  dec_assoc;

    region_e               cap_region;
    logic                  cap_way;
    logic [ENTRY_BITS-1:0] cap_idx;
    logic [WORD_BITS-1:0]  cap_word;
    logic [31:0]           cap_wdata;

    logic                  accept;
    logic                  tag_wr_en, tag_wr_tag_en, tag_wr_way;
    logic [ENTRY_BITS-1:0] tag_wr_idx;
    logic [TAG_W-1:0]      tag_wr_tag;
    logic                  tag_wr_valid, tag_wr_dirty;
    logic [TAG_W-1:0]      st_tag;
    logic                  st_valid, st_dirty;
    logic                  data_wr_en;
    logic [31:0]           st_data;
    logic                  assoc_match;

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^req_wdata;

    ocw_decode #(
        .ENTRY_BITS (ENTRY_BITS),
        .ENTRY_LSB  (ENTRY_LSB),
        .WORD_BITS  (WORD_BITS),
        .WAY_BIT    (WAY_BIT),
        .RAM_WAY_BIT(RAM_WAY_BIT)
    ) u_decode (
        .addr    (req_addr),
        .ram_mode(ram_mode),
        .region  (dec_region),
        .way     (dec_way),
        .idx     (dec_idx),
        .word    (dec_word),
        .assoc   (dec_assoc)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture for the response and associative-check states
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_region <= RGN_NONE;
            cap_way    <= 1'b0;
            cap_idx    <= '0;
            cap_word   <= '0;
            cap_wdata  <= '0;
        end else if (accept) begin
            cap_region <= dec_region;
            cap_way    <= dec_way;
            cap_idx    <= dec_idx;
            cap_word   <= dec_word;
            cap_wdata  <= req_wdata;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write) begin
                        state_d = ST_READ_RESP;
                    end else if (dec_region == RGN_TAG && dec_assoc) begin
                        state_d = ST_ASSOC_CHECK;
                    end
                end
            end
            ST_READ_RESP:   state_d = ST_IDLE;
            ST_ASSOC_CHECK: state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    assign assoc_match = (st_tag == cap_wdata[31:TAG_LSB]);

    // Output and array-control logic
    always_comb begin
        req_ready     = 1'b0;
        rsp_valid     = 1'b0;
        rsp_rdata     = '0;
        accept        = 1'b0;
        tag_wr_en     = 1'b0;
        tag_wr_tag_en = 1'b0;
        tag_wr_way    = dec_way;
        tag_wr_idx    = dec_idx;
        tag_wr_tag    = req_wdata[31:TAG_LSB];
        tag_wr_valid  = req_wdata[VALID_BIT];
        tag_wr_dirty  = req_wdata[DIRTY_BIT];
        data_wr_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                accept    = req_valid;
                if (req_valid && req_write) begin
                    if (dec_region == RGN_TAG && !dec_assoc) begin
                        tag_wr_en     = 1'b1;
                        tag_wr_tag_en = 1'b1;
                    end
                    if (dec_region == RGN_DATA) begin
                        data_wr_en = 1'b1;
                    end
                end
            end
            ST_READ_RESP: begin
                rsp_valid = 1'b1;
                unique case (cap_region)
                    RGN_TAG:  rsp_rdata = {st_tag, {RSV_W{1'b0}}, st_dirty, st_valid};
                    RGN_DATA: rsp_rdata = st_data;
                    default:  rsp_rdata = '0;
                endcase
            end
            ST_ASSOC_CHECK: begin
                tag_wr_way   = cap_way;
                tag_wr_idx   = cap_idx;
                tag_wr_valid = cap_wdata[VALID_BIT];
                tag_wr_dirty = cap_wdata[DIRTY_BIT];
                tag_wr_en    = assoc_match;
            end
            default: ;
        endcase
    end

    ocw_tag_store #(
        .ENTRY_BITS(ENTRY_BITS)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tag_wr_en),
        .wr_way   (tag_wr_way),
        .wr_idx   (tag_wr_idx),
        .wr_tag_en(tag_wr_tag_en),
        .wr_tag   (tag_wr_tag),
        .wr_valid (tag_wr_valid),
        .wr_dirty (tag_wr_dirty),
        .rd_way   (cap_way),
        .rd_idx   (cap_idx),
        .rd_tag   (st_tag),
        .rd_valid (st_valid),
        .rd_dirty (st_dirty)
    );

    ocw_data_store #(
        .ENTRY_BITS(ENTRY_BITS),
        .WORD_BITS (WORD_BITS)
    ) u_data (
        .clk    (clk),
        .wr_en  (data_wr_en),
        .wr_way (dec_way),
        .wr_idx (dec_idx),
        .wr_word(dec_word),
        .wr_data(req_wdata),
        .rd_way (cap_way),
        .rd_idx (cap_idx),
        .rd_word(cap_word),
        .rd_data(st_data)
    );

endmodule

// File: rtl/ocw_checker.sv
module ocw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata
);

    logic rd_acc;
    logic outside;
    assign rd_acc  = req_valid && req_ready && !req_write;
    assign outside = (req_addr[31:24] != 8'hF4) && (req_addr[31:24] != 8'hF5);

    assert_read_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rsp_valid);

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_busy_in_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_assoc_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_addr[31:24] == 8'hF4 && req_addr[3])
        |=> (!req_ready && !rsp_valid));

    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && req_addr[31:24] == 8'hF4) |=> (rsp_rdata[9:2] == 8'h00));

    assert_outside_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && outside) |=> (rsp_rdata == 32'h0));

endmodule

bind opcache_window ocw_checker u_ocw_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
);

// File: tb/test_opcache_window.sv
`timescale 1ns/1ps
module test_opcache_window;

    localparam int ENT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ram_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int errors = 0;
    int checks = 0;
    bit exp_rv = 1'b0;
    bit done = 1'b0;

    logic [21:0] m_tag  [2*ENT];
    bit          m_v    [2*ENT];
    bit          m_d    [2*ENT];
    bit          m_tk   [2*ENT];
    logic [31:0] m_data [2*ENT*8];
    bit          m_dk   [2*ENT*8];

    always #2.5 clk = ~clk;

    opcache_window i_opcache_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .ram_mode (ram_mode),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Every clock: response strobe compared with the model's expectation (R10)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(rsp_valid === exp_rv, "R10 rsp_valid", 32'(rsp_valid), 32'(exp_rv));
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic int line_key(input logic [31:0] a, input bit ram);
        int w;
        w = ram ? int'(a[13]) : int'(a[14]);
        return w * ENT + int'(a[8:5]);
    endfunction

    function automatic logic [31:0] mk(input logic [7:0] rg, input int way, input int idx,
                                       input int word, input bit asc, input bit ram);
        logic [31:0] a;
        a = {rg, 24'h0};
        if (ram) a[13] = way[0]; else a[14] = way[0];
        a[8:5] = idx[3:0];
        a[4:2] = word[2:0];
        if (asc) a[3] = 1'b1;
        return a;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2*ENT; i++) begin
            m_v[i] = 0;
            m_d[i] = 0;
        end
    endtask

    task automatic model_write(input logic [31:0] a, input logic [31:0] wd, input bit ram);
        int k;
        k = line_key(a, ram);
        if (a[31:24] == 8'hF4) begin
            if (a[3]) begin
                if (m_tk[k] && m_tag[k] == wd[31:10]) begin
                    m_v[k] = wd[0];
                    m_d[k] = wd[1];
                end
            end else begin
                m_tag[k] = wd[31:10];
                m_tk[k]  = 1;
                m_v[k]   = wd[0];
                m_d[k]   = wd[1];
            end
        end else if (a[31:24] == 8'hF5) begin
            m_data[k*8 + int'(a[4:2])] = wd;
            m_dk[k*8 + int'(a[4:2])]   = 1;
        end
    endtask

    task automatic xfer(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        input bit ram, output logic [31:0] rd);
        @(negedge clk);
        ram_mode  = ram;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        exp_rv = !wr;
        if (wr) model_write(a, wd, ram);
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata;
        if (!wr) begin
            @(posedge clk);
            exp_rv = 1'b0;
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] wd, input bit ram);
        logic [31:0] dummy;
        xfer(1'b1, a, wd, ram, dummy);
    endtask

    task automatic rd_check(input logic [31:0] a, input bit ram, input string req);
        logic [31:0] got, exp, mask;
        int k;
        xfer(1'b0, a, 32'h0, ram, got);
        k = line_key(a, ram);
        exp = 32'h0;
        mask = 32'hFFFF_FFFF;
        if (a[31:24] == 8'hF4) begin
            exp = {m_tag[k], 8'h00, m_d[k], m_v[k]};
            if (!m_tk[k]) mask = 32'h0000_03FF;
        end else if (a[31:24] == 8'hF5) begin
            exp = m_data[k*8 + int'(a[4:2])];
            if (!m_dk[k*8 + int'(a[4:2])]) mask = 32'h0;
        end
        check((got & mask) === (exp & mask), req, got, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        exp_rv = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 2*ENT; i++) begin
            m_tk[i] = 0;
            m_tag[i] = '0;
        end
        for (int i = 0; i < 2*ENT*8; i++) begin
            m_dk[i] = 0;
            m_data[i] = '0;
        end
        model_reset();
        do_reset();

        // Reset state
        check(req_ready === 1'b1, "R10 idle ready after reset", 32'(req_ready), 32'h1);
        check(rsp_valid === 1'b0, "R10 no response after reset", 32'(rsp_valid), 32'h0);
        rd_check(mk(8'hF4, 0, 0, 0, 0, 0), 0, "R11 way0 line0 clear");
        rd_check(mk(8'hF4, 1, 15, 0, 0, 0), 0, "R11 way1 line15 clear");

        // Plain tag writes with reserved bits set to ones (R6, R5, R2)
        wr(mk(8'hF4, 0, 3, 0, 0, 0), 32'hABCD_E3FF, 0);
        wr(mk(8'hF4, 1, 3, 0, 0, 0), 32'h1234_5401, 0);
        wr(mk(8'hF4, 0, 9, 0, 0, 0), 32'hFFFF_FC02, 0);
        rd_check(mk(8'hF4, 0, 3, 0, 0, 0), 0, "R6 R5 way0 line3");
        rd_check(mk(8'hF4, 1, 3, 0, 0, 0), 0, "R2 way1 line3");
        rd_check(mk(8'hF4, 0, 9, 0, 0, 0), 0, "R6 way0 line9");
        wr(mk(8'hF4, 0, 3, 0, 0, 0), 32'h0000_0C00, 0);
        rd_check(mk(8'hF4, 0, 3, 0, 0, 0), 0, "R6 overwrite");

        // Data words (R3, R2, R1)
        for (int w = 0; w < 8; w++) wr(mk(8'hF5, 0, 3, w, 0, 0) | 32'(w % 4), 32'hD000_0000 + 32'(w), 0);
        wr(mk(8'hF5, 1, 3, 5, 0, 0), 32'h5555_AAAA, 0);
        for (int w = 0; w < 8; w++) rd_check(mk(8'hF5, 0, 3, w, 0, 0), 0, "R3 word select");
        rd_check(mk(8'hF5, 1, 3, 5, 0, 0), 0, "R2 data way1");
        rd_check(mk(8'hF4, 1, 3, 0, 0, 0), 0, "R1 tag untouched by data");
        wr(mk(8'hF4, 1, 3, 0, 0, 0), 32'h8888_8803, 0);
        rd_check(mk(8'hF5, 1, 3, 5, 0, 0), 0, "R1 data untouched by tag");

        // RAM mode: bit 13 picks the way, bit 14 ignored (R4)
        wr(mk(8'hF5, 1, 7, 2, 0, 1), 32'hCAFE_0001, 1);
        wr(mk(8'hF5, 0, 7, 2, 0, 1) | 32'h0000_4000, 32'hBEEF_0002, 1);
        rd_check(mk(8'hF5, 1, 7, 2, 0, 0), 0, "R4 ram way1 seen as way1");
        rd_check(mk(8'hF5, 0, 7, 2, 0, 0), 0, "R4 bit14 ignored in ram mode");
        wr(mk(8'hF4, 1, 7, 0, 0, 0) | 32'h0000_2000, 32'h7777_7401, 0);
        rd_check(mk(8'hF4, 1, 7, 0, 0, 0), 0, "R2 bit13 ignored normal mode");

        // Associative hit (R7) and miss (R8)
        wr(mk(8'hF4, 1, 3, 0, 1, 0), 32'h8888_8800, 0);
        rd_check(mk(8'hF4, 1, 3, 0, 0, 0), 0, "R7 assoc hit clears v/d");
        wr(mk(8'hF4, 0, 9, 0, 1, 0), 32'hFFFF_FC01, 0);
        rd_check(mk(8'hF4, 0, 9, 0, 0, 0), 0, "R7 assoc hit sets v only");
        wr(mk(8'hF4, 0, 9, 0, 1, 0), 32'h0000_0403, 0);
        rd_check(mk(8'hF4, 0, 9, 0, 0, 0), 0, "R8 assoc miss no change");
        wr(mk(8'hF4, 1, 7, 0, 1, 0), 32'h7777_7C02, 0);
        rd_check(mk(8'hF4, 1, 7, 0, 0, 0), 0, "R8 assoc miss near tag");
        wr(mk(8'hF4, 0, 9, 0, 1, 1), 32'hFFFF_FC03, 1);
        rd_check(mk(8'hF4, 0, 9, 0, 0, 0), 0, "R7 R4 assoc hit in ram mode");

        // Outside the mapped regions (R9)
        wr(mk(8'hF6, 0, 9, 0, 0, 0), 32'h0000_0000, 0);
        wr(mk(8'hE4, 1, 3, 5, 0, 0), 32'h0000_0000, 0);
        wr(mk(8'h74, 0, 9, 0, 0, 0), 32'h0000_0000, 0);
        rd_check(mk(8'hF4, 0, 9, 0, 0, 0), 0, "R9 tag line unchanged");
        rd_check(mk(8'hF5, 1, 3, 5, 0, 0), 0, "R9 data word unchanged");
        rd_check(mk(8'hF6, 0, 9, 0, 0, 0), 0, "R9 outside read zero");
        rd_check(32'h8000_0000, 0, "R9 far outside read zero");

        // Second reset clears status (R11)
        do_reset();
        rd_check(mk(8'hF4, 0, 9, 0, 0, 0), 0, "R11 way0 line9 cleared");
        rd_check(mk(8'hF4, 1, 7, 0, 0, 0), 0, "R11 way1 line7 cleared");
        rd_check(mk(8'hF4, 0, 3, 0, 0, 0), 0, "R11 way0 line3 cleared");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule